// File: doc/BRIEF.md
# Directory Home-Node Invalidation Controller

This block is the home side of a write-invalidate coherence scheme for one slice of distributed memory. Each block of the slice has one directory entry. The entry records a global state (uncached, read-shared or exclusive), the owning node, and a bitmap of the nodes that hold a copy. Remote caches send read misses and ownership requests to the controller as single-beat messages. The controller answers in one of three ways:

- it replies directly;
- it forwards the request to the current owner, who then supplies the data to the requester;
- it invalidates every other copy, counts the acknowledgements, and grants ownership once the last one has arrived.

A block with a transaction outstanding is marked busy. Any read or ownership request that reaches it while it is busy is turned away with a negative acknowledgement, and the requester retries.

Only one message is handled at a time. The controller accepts a request, reads the entry, decides, writes the updated entry back, and then emits zero or more response messages through a registered valid/ready output. After reset a sweep clears every entry to uncached. The controller accepts no requests until the sweep has finished.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` and `rsp_valid` stay low for exactly BLOCKS cycles while the directory is cleared. After that every block is uncached.
- R2: A read miss (req_type 0) gets a DATA reply (rsp_type 0) to the requester, with rsp_aux equal to the requester, unless the block is exclusive at a node other than the requester and the home. The block then becomes read-shared, with the requester added to the sharers.
- R3: A read miss on a block held exclusively by a remote node produces a forward-read (rsp_type 2) to that owner, with rsp_aux set to the requester. When the owner then sends completion (req_type 3), the block becomes read-shared by the old owner and the requester, and no response is sent.
- R4: An ownership request (req_type 1) is granted directly (rsp_type 1, to the requester) when no node other than the requester and the home holds the block. The block becomes exclusive at the requester, and the requester becomes its only sharer.
- R5: An ownership request on a block held exclusively by a remote node produces a forward-ownership (rsp_type 3) to the owner, with rsp_aux set to the requester. The owner's completion makes the requester the exclusive owner.
- R6: An ownership request on a read-shared block with other sharers sends one invalidation (rsp_type 4, rsp_aux set to the requester) to each sharer other than the requester and the home, in ascending node order. The grant follows only after the acknowledgement (req_type 2) that brings the count of received acknowledgements up to the number of invalidations.
- R7: While a block is busy, a read or ownership request for it gets a NACK (rsp_type 5) to the sender, and the entry is left unchanged.
- R8: An acknowledgement or completion that matches no outstanding transaction on its block produces no response and changes nothing.
- R9: A response stays valid and unchanged until `rsp_ready` is seen high. No request is accepted while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Controller can take a request |
| req_type | input | 2 | 0 read miss, 1 ownership, 2 inval ack, 3 forward completion |
| req_src | input | $clog2(NODES) | Sending node |
| req_addr | input | $clog2(BLOCKS) | Block index within this slice |
| rsp_valid | output | 1 | Response message present |
| rsp_ready | input | 1 | Network accepts the response |
| rsp_type | output | 3 | 0 data, 1 grant, 2 fwd read, 3 fwd own, 4 inval, 5 nack |
| rsp_dst | output | $clog2(NODES) | Destination node |
| rsp_aux | output | $clog2(NODES) | Requesting node the message concerns |
| rsp_addr | output | $clog2(BLOCKS) | Block index |

## Verification
The invalidation path is swept exhaustively on a four-node configuration with the home at node 0. Every possible sharer set is built up through read misses, and an ownership request then comes from every node in turn. This separates three cases: sets that need no invalidation (empty, requester only, home only), the order of the invalidation walk, and the exact acknowledgement on which the grant appears. Each sweep case then reads the block from a neighbouring node, which shows whether ownership landed on the right node. Directed sequences cover the owner forwards, NACKs on busy blocks, completions from the wrong node and stray acknowledgements. A stalled output during an invalidation burst checks that the response holds still under backpressure.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;

  typedef enum logic [1:0] {
    MSG_READ = 2'd0,
    MSG_OWN  = 2'd1,
    MSG_ACK  = 2'd2,
    MSG_DONE = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    RSP_DATA    = 3'd0,
    RSP_GRANT   = 3'd1,
    RSP_FWD_RD  = 3'd2,
    RSP_FWD_OWN = 3'd3,
    RSP_INVAL   = 3'd4,
    RSP_NACK    = 3'd5
  } rsp_kind_e;

  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_FRD  = 2'd1,
    PEND_FOWN = 2'd2,
    PEND_INV  = 2'd3
  } pend_kind_e;

  // index of the lowest set bit, 0 when none
  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int W     = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // single write port, registered read: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dir_policy.sv
module dir_policy
  import dirctl_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int HOME_ID = 0,
  parameter int NW      = 3,
  parameter int CW      = 4
) (
  input  blk_state_e       e_state,
  input  logic [NW-1:0]    e_owner,
  input  logic [NODES-1:0] e_shr,
  input  logic             e_busy,
  input  pend_kind_e       e_kind,
  input  logic [NW-1:0]    e_pend,
  input  logic [CW-1:0]    e_cnt,
  input  req_kind_e        r_kind,
  input  logic [NW-1:0]    r_src,
  output blk_state_e       n_state,
  output logic [NW-1:0]    n_owner,
  output logic [NODES-1:0] n_shr,
  output logic             n_busy,
  output pend_kind_e       n_kind,
  output logic [NW-1:0]    n_pend,
  output logic [CW-1:0]    n_cnt,
  output logic             o_emit,
  output rsp_kind_e        o_type,
  output logic [NW-1:0]    o_dst,
  output logic [NW-1:0]    o_aux,
  output logic [NODES-1:0] o_left
);

  localparam logic [NW-1:0] HOME = NW'(HOME_ID);

  logic [NODES-1:0] src_oh, home_oh, pend_oh, own_oh, others;
  logic             remote_own;
  logic [NW-1:0]    first_oth;

  always_comb begin
    src_oh     = NODES'(1) << r_src;
    home_oh    = NODES'(1) << HOME;
    pend_oh    = NODES'(1) << e_pend;
    own_oh     = NODES'(1) << e_owner;
    others     = e_shr & ~src_oh & ~home_oh;
    remote_own = (e_state == BLK_EXC) && (e_owner != r_src) && (e_owner != HOME);
    first_oth  = NW'(first_set(32'(others)));
  end

  always_comb begin
    n_state = e_state;
    n_owner = e_owner;
    n_shr   = e_shr;
    n_busy  = e_busy;
    n_kind  = e_kind;
    n_pend  = e_pend;
    n_cnt   = e_cnt;
    o_emit  = 1'b0;
    o_type  = RSP_DATA;
    o_dst   = r_src;
    o_aux   = r_src;
    o_left  = '0;
    if (e_busy) begin
      case (r_kind)
        MSG_READ, MSG_OWN: begin
          o_emit = 1'b1;
          o_type = RSP_NACK;
        end
        MSG_ACK: begin
          if (e_kind == PEND_INV) begin
            if (e_cnt == CW'(1)) begin
              n_state = BLK_EXC;
              n_owner = e_pend;
              n_shr   = pend_oh;
              n_busy  = 1'b0;
              n_kind  = PEND_NONE;
              n_cnt   = '0;
              o_emit  = 1'b1;
              o_type  = RSP_GRANT;
              o_dst   = e_pend;
              o_aux   = e_pend;
            end else begin
              n_cnt = CW'(e_cnt - CW'(1));
            end
          end
        end
        default: begin
          if (e_kind != PEND_INV && e_kind != PEND_NONE && r_src == e_owner) begin
            n_busy = 1'b0;
            n_kind = PEND_NONE;
            if (e_kind == PEND_FRD) begin
              n_state = BLK_SHR;
              n_shr   = own_oh | pend_oh;
            end else begin
              n_state = BLK_EXC;
              n_owner = e_pend;
              n_shr   = pend_oh;
            end
          end
        end
      endcase
    end else begin
      case (r_kind)
        MSG_READ: begin
          o_emit = 1'b1;
          if (remote_own) begin
            o_type = RSP_FWD_RD;
            o_dst  = e_owner;
            n_busy = 1'b1;
            n_kind = PEND_FRD;
            n_pend = r_src;
          end else begin
            n_state = BLK_SHR;
            n_shr   = e_shr | src_oh;
          end
        end
        MSG_OWN: begin
          o_emit = 1'b1;
          if (remote_own) begin
            o_type = RSP_FWD_OWN;
            o_dst  = e_owner;
            n_busy = 1'b1;
            n_kind = PEND_FOWN;
            n_pend = r_src;
          end else if (|others) begin
            o_type = RSP_INVAL;
            o_dst  = first_oth;
            o_left = others & ~(NODES'(1) << first_oth);
            n_busy = 1'b1;
            n_kind = PEND_INV;
            n_pend = r_src;
            n_cnt  = CW'($countones(others));
          end else begin
            o_type  = RSP_GRANT;
            n_state = BLK_EXC;
            n_owner = r_src;
            n_shr   = src_oh;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dirctl_pkg::*;
#(
  parameter int NODES   = 8,
  parameter int BLOCKS  = 64,
  parameter int HOME_ID = 0,
  localparam int NW = $clog2(NODES),
  localparam int AW = $clog2(BLOCKS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [NW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [2:0]    rsp_type,
  output logic [NW-1:0] rsp_dst,
  output logic [NW-1:0] rsp_aux,
  output logic [AW-1:0] rsp_addr
);

  localparam int CW = $clog2(NODES + 1);

  typedef struct packed {
    blk_state_e       st;
    logic [NW-1:0]    own;
    logic [NODES-1:0] shr;
    logic             busy;
    pend_kind_e       pk;
    logic [NW-1:0]    pnd;
    logic [CW-1:0]    cnt;
  } dir_ent_t;

  localparam int EW = $bits(dir_ent_t);

  typedef enum logic [1:0] {S_CLR, S_IDLE, S_LOOK, S_SEND} fsm_e;

  fsm_e             state;
  logic [AW-1:0]    clr_idx;
  req_kind_e        lat_kind;
  logic [NW-1:0]    lat_src;
  logic [AW-1:0]    lat_addr;
  logic [NODES-1:0] left;
  logic [NW-1:0]    nxt_dst;

  logic          st_we;
  logic [AW-1:0] st_waddr;
  logic [EW-1:0] st_wdata, st_rdata;
  dir_ent_t      rd_ent, new_ent;

  logic             p_emit;
  rsp_kind_e        p_type;
  logic [NW-1:0]    p_dst, p_aux;
  logic [NODES-1:0] p_left;

  assign req_ready = (state == S_IDLE);
  assign rd_ent    = dir_ent_t'(st_rdata);
  assign nxt_dst   = NW'(first_set(32'(left)));

  always_comb begin
    st_we    = (state == S_CLR) || (state == S_LOOK);
    st_waddr = (state == S_CLR) ? clr_idx : lat_addr;
    st_wdata = (state == S_CLR) ? '0 : EW'(new_ent);
  end

  dir_store #(.DEPTH(BLOCKS), .AW(AW), .W(EW)) store_i (
    .clk   (clk),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (req_addr),
    .rdata (st_rdata)
  );

  dir_policy #(.NODES(NODES), .HOME_ID(HOME_ID), .NW(NW), .CW(CW)) policy_i (
    .e_state (rd_ent.st),
    .e_owner (rd_ent.own),
    .e_shr   (rd_ent.shr),
    .e_busy  (rd_ent.busy),
    .e_kind  (rd_ent.pk),
    .e_pend  (rd_ent.pnd),
    .e_cnt   (rd_ent.cnt),
    .r_kind  (lat_kind),
    .r_src   (lat_src),
    .n_state (new_ent.st),
    .n_owner (new_ent.own),
    .n_shr   (new_ent.shr),
    .n_busy  (new_ent.busy),
    .n_kind  (new_ent.pk),
    .n_pend  (new_ent.pnd),
    .n_cnt   (new_ent.cnt),
    .o_emit  (p_emit),
    .o_type  (p_type),
    .o_dst   (p_dst),
    .o_aux   (p_aux),
    .o_left  (p_left)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_CLR;
      clr_idx   <= '0;
      lat_kind  <= MSG_READ;
      lat_src   <= '0;
      lat_addr  <= '0;
      left      <= '0;
      rsp_valid <= 1'b0;
      rsp_type  <= '0;
      rsp_dst   <= '0;
      rsp_aux   <= '0;
      rsp_addr  <= '0;
    end else begin
      case (state)
        S_CLR: begin
          clr_idx <= clr_idx + AW'(1);
          if (clr_idx == AW'(BLOCKS - 1)) state <= S_IDLE;
        end
        S_IDLE: begin
          if (req_valid) begin
            lat_kind <= req_kind_e'(req_type);
            lat_src  <= req_src;
            lat_addr <= req_addr;
            state    <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (p_emit) begin
            rsp_valid <= 1'b1;
            rsp_type  <= p_type;
            rsp_dst   <= p_dst;
            rsp_aux   <= p_aux;
            rsp_addr  <= lat_addr;
            left      <= p_left;
            state     <= S_SEND;
          end else begin
            state <= S_IDLE;
          end
        end
        default: begin
          if (rsp_ready) begin
            if (|left) begin
              rsp_type <= RSP_INVAL;
              rsp_dst  <= nxt_dst;
              left     <= left & ~(NODES'(1) << nxt_dst);
            end else begin
              rsp_valid <= 1'b0;
              state     <= S_IDLE;
            end
          end
        end
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_type) && $stable(rsp_dst)
      && $stable(rsp_aux) && $stable(rsp_addr)); // R9

  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R9

  AST_INVAL_TARGET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_type == 3'(RSP_INVAL) |-> rsp_dst != rsp_aux && rsp_dst != NW'(HOME_ID)); // R6

  AST_ACK_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
    state == S_LOOK && rd_ent.busy && rd_ent.pk == PEND_INV |-> rd_ent.cnt != '0); // R6

  AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (rst)
    st_we && state != S_LOOK |-> !rsp_valid); // R1

endmodule

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb_top;

  localparam int NODES  = 4;
  localparam int BLOCKS = 128;
  localparam int NW = $clog2(NODES);
  localparam int AW = $clog2(BLOCKS);

  localparam int T_READ = 0, T_OWN = 1, T_ACK = 2, T_DONE = 3;
  localparam int K_DATA = 0, K_GRANT = 1, K_FRD = 2, K_FOWN = 3, K_INV = 4, K_NACK = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, rsp_valid, rsp_ready;
  logic [1:0]    req_type;
  logic [NW-1:0] req_src, rsp_dst, rsp_aux;
  logic [AW-1:0] req_addr, rsp_addr;
  logic [2:0]    rsp_type;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .HOME_ID(0)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
    .rsp_dst(rsp_dst), .rsp_aux(rsp_aux), .rsp_addr(rsp_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input int t, input int src, input int addr);
    @(negedge clk);
    req_valid = 1'b1;
    req_type  = 2'(t);
    req_src   = NW'(src);
    req_addr  = AW'(addr);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input int t, input int dst, input int aux, input int addr,
                            input string tag);
    bit got;
    int act, exp;
    got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rsp_valid) begin
        got = 1'b1;
        break;
      end
    end
    exp = (t << 16) | (dst << 12) | (aux << 8) | addr;
    act = (int'(rsp_type) << 16) | (int'(rsp_dst) << 12) | (int'(rsp_aux) << 8) | int'(rsp_addr);
    if (!got) act = 32'hdead;
    chk(got && act == exp, tag, act, exp);
  endtask

  task automatic expect_none(input int n, input string tag);
    bit bad;
    bad = 1'b0;
    repeat (n) begin
      @(negedge clk);
      if (rsp_valid) bad = 1'b1;
    end
    chk(!bad, tag, int'(bad), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    rst = 1'b1;
    req_valid = 1'b0;
    req_type = '0;
    req_src = '0;
    req_addr = '0;
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(!req_ready && !rsp_valid, "R1 quiet in reset", int'(req_ready), 0);
    rst = 1'b0;
    cnt = 0;
    while (!req_ready && cnt < 1000) begin
      if (rsp_valid) chk(1'b0, "R1 rsp during clear", 1, 0);
      @(negedge clk);
      cnt++;
    end
    chk(cnt == BLOCKS, "R1 clear length", cnt, BLOCKS);

    // exhaustive sweep: every sharer set, ownership from every node
    for (int m = 0; m < 16; m++) begin
      for (int r = 0; r < 4; r++) begin
        int blk, oth, last, q;
        blk = m * 4 + r;
        oth = m & ~(1 << r) & ~1;
        last = -1;
        for (int n = 0; n < 4; n++) begin
          if ((m >> n) & 1) begin
            send(T_READ, n, blk);
            expect_rsp(K_DATA, n, n, blk, "R2 read data");
          end
          if ((oth >> n) & 1) last = n;
        end
        send(T_OWN, r, blk);
        if (oth == 0) begin
          expect_rsp(K_GRANT, r, r, blk, "R4 direct grant");
        end else begin
          for (int n = 0; n < 4; n++)
            if ((oth >> n) & 1) expect_rsp(K_INV, n, r, blk, "R6 inval order");
          for (int n = 0; n < 4; n++) begin
            if ((oth >> n) & 1) begin
              send(T_ACK, n, blk);
              if (n != last) expect_none(3, "R6 no early grant");
              else expect_rsp(K_GRANT, r, r, blk, "R6 grant after acks");
            end
          end
        end
        q = (r + 1) % 4;
        send(T_READ, q, blk);
        if (r != 0) begin
          expect_rsp(K_FRD, r, q, blk, "R4 owner after grant");
          send(T_DONE, r, blk);
          expect_none(2, "R3 done silent");
        end else begin
          expect_rsp(K_DATA, q, q, blk, "R4 home owner read");
        end
      end
    end

    // forwarded read, busy nack, wrong completion
    send(T_OWN, 2, 100);
    expect_rsp(K_GRANT, 2, 2, 100, "R4 grant uncached");
    send(T_READ, 3, 100);
    expect_rsp(K_FRD, 2, 3, 100, "R3 forward read");
    send(T_READ, 1, 100);
    expect_rsp(K_NACK, 1, 1, 100, "R7 nack read busy");
    send(T_DONE, 3, 100);
    expect_none(3, "R8 done from non-owner");
    send(T_OWN, 1, 100);
    expect_rsp(K_NACK, 1, 1, 100, "R8 entry still busy");
    send(T_DONE, 2, 100);
    expect_none(3, "R3 completion silent");
    send(T_OWN, 1, 100);
    expect_rsp(K_INV, 2, 1, 100, "R3 sharer old owner");
    expect_rsp(K_INV, 3, 1, 100, "R3 sharer requester");
    send(T_ACK, 2, 100);
    expect_none(3, "R6 first ack");
    send(T_ACK, 3, 100);
    expect_rsp(K_GRANT, 1, 1, 100, "R6 grant");

    // forwarded ownership
    send(T_OWN, 3, 101);
    expect_rsp(K_GRANT, 3, 3, 101, "R4 grant");
    send(T_OWN, 1, 101);
    expect_rsp(K_FOWN, 3, 1, 101, "R5 forward own");
    send(T_OWN, 2, 101);
    expect_rsp(K_NACK, 2, 2, 101, "R7 nack own busy");
    send(T_DONE, 3, 101);
    expect_none(3, "R5 completion silent");
    send(T_READ, 2, 101);
    expect_rsp(K_FRD, 1, 2, 101, "R5 new owner");

    // stray messages on an idle block
    send(T_ACK, 2, 102);
    expect_none(3, "R8 stray ack");
    send(T_DONE, 1, 102);
    expect_none(3, "R8 stray done");
    send(T_OWN, 1, 102);
    expect_rsp(K_GRANT, 1, 1, 102, "R8 block still uncached");

    // backpressure during an invalidation burst
    send(T_READ, 1, 103);
    expect_rsp(K_DATA, 1, 1, 103, "R2");
    send(T_READ, 2, 103);
    expect_rsp(K_DATA, 2, 2, 103, "R2");
    send(T_READ, 3, 103);
    expect_rsp(K_DATA, 3, 3, 103, "R2");
    @(negedge clk);
    rsp_ready = 1'b0;
    send(T_OWN, 1, 103);
    begin
      int w;
      bit moved;
      w = 0;
      while (!rsp_valid && w < 20) begin
        @(negedge clk);
        w++;
      end
      moved = 1'b0;
      repeat (4) begin
        @(negedge clk);
        if (!rsp_valid || rsp_type != 3'(K_INV) || rsp_dst != NW'(2) || req_ready) moved = 1'b1;
      end
      chk(!moved, "R9 hold under stall", int'(moved), 0);
      rsp_ready = 1'b1;
      chk(rsp_valid && rsp_dst == NW'(2), "R9 first inval kept", int'(rsp_dst), 2);
    end
    expect_rsp(K_INV, 3, 1, 103, "R9 second inval");
    send(T_ACK, 2, 103);
    expect_none(2, "R6");
    send(T_ACK, 3, 103);
    expect_rsp(K_GRANT, 1, 1, 103, "R6");

    finish_run();
  end

endmodule